// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital core of a 10-bit successive-approximation converter that sits on an 8-bit processor bus. A processor starts a conversion with a write strobe. The block then drives a trial code to an external DAC and comparator and builds the result one bit at a time, starting from the top bit. When the search ends, the block latches the result and signals completion with an active-low interrupt. The processor then fetches the code as two bytes, with the result left-justified.

Chip select, write and read are asynchronous and pass through two-flop synchronisers. Start is level-based. While select and write are both low, the search logic stays cleared. The search begins on the first clock after either strobe goes high, so a start pulse may be any width. Each bit decision takes a fixed number of clocks.

The interrupt flag is set by a one-shot of fixed length. Because this set has priority over the clear, an interrupt edge still appears when the read path is held enabled. This priority also allows a free-running loop, in which write is wired to the interrupt output and select is tied low.

Top module: `sar_conv_ctrl`

## Requirements
- R1: While synchronised chip select and write are both low, the trial code on `dac_code_o` is zero, no interrupt is raised, and the interrupt flag is cleared once any set pulse has ended.
- R2: The search starts only after select or write returns high. `intr_no` falls between 80 and 90 clocks after that release, with 8 clocks per bit.
- R3: The search goes from the top bit down. The first trial code is 0x200. Each later trial keeps the bits already decided and sets the next lower bit. A comparator value of 1 keeps the bit under trial.
- R4: The latched result equals the binary-search outcome for the comparator model `cmp_i = (input >= trial)`. An input of 0x3FF gives 0x3FF, and a comparator that is always 0 gives 0x000.
- R5: At the end of a conversion, `intr_no` falls and stays low until it is cleared by a read or a start. After reset it is high.
- R6: Select and read both low assert `data_oe_o` and clear the interrupt once the set pulse has ended.
- R7: If select and read are held low throughout a conversion, `intr_no` is still low for exactly INTR_PULSE (default 20) clocks.
- R8: The first byte is result[9:2] on data bits 7..0. The second byte is {result[1:0], 6'b0}. `data_o` is 0 whenever `data_oe_o` is low.
- R9: The byte pointer returns to the first byte when a conversion starts. It advances on each rising edge of read while select is low, and wraps after the second byte.
- R10: With select tied low and write driven from `intr_no`, a single forced low pulse starts conversions that then repeat without further intervention.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion and bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| wr_ni | input | 1 | Write / start strobe, active low, asynchronous |
| rd_ni | input | 1 | Read strobe, active low, asynchronous |
| cmp_i | input | 1 | Comparator decision: 1 when the input is at or above the trial code |
| dac_code_o | output | 10 | Trial code to the external DAC |
| intr_no | output | 1 | End-of-conversion interrupt, active low |
| data_o | output | 8 | Byte-wide result, zero while not enabled |
| data_oe_o | output | 1 | Output enable for the data bus |

## Verification
A marker or phase counter that slips shows at the ports within one bit period in two ways: a trial code that is not 0x200 early in the search, or a completion edge outside the 80 to 90 clock window. A wrong bit decision or a faulty latch transfer appears as a wrong byte pair on the first read after completion. A byte pointer that fails to reset or to wrap returns the wrong half-word on the next read. An interrupt set that loses priority to the clear shows within a single conversion, as a zero-length or missing low pulse while reads are held enabled.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_RUN  = 2'd2
  } seq_st_e;
endpackage

// File: rtl/sar_sync.sv
`timescale 1ns/1ps
module sar_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[g];
        s2_q <= RST_VAL[g];
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/sar_seq.sv
`timescale 1ns/1ps
module sar_seq
  import sar_pkg::*;
#(
  parameter int RES_BITS     = 10,
  parameter int CLKS_PER_BIT = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_req_i,
  input  logic                cmp_i,
  output logic [RES_BITS-1:0] trial_o,
  output logic [RES_BITS-1:0] result_o,
  output logic                xfer_o
);
  localparam int PH_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [PH_W-1:0]     PH_LAST = PH_W'(CLKS_PER_BIT - 1);
  localparam logic [RES_BITS-1:0] MSB_ONE = {1'b1, {(RES_BITS-1){1'b0}}};

  seq_st_e             state_q;
  logic [RES_BITS-1:0] mark_q, sar_q, res_q;
  logic [PH_W-1:0]     phase_q;
  logic                xfer_q;
  logic [RES_BITS-1:0] keep;

  assign keep = cmp_i ? mark_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mark_q  <= '0;
      sar_q   <= '0;
      res_q   <= '0;
      phase_q <= '0;
      xfer_q  <= 1'b0;
    end else begin
      xfer_q <= 1'b0;
      if (start_req_i) begin
        state_q <= ST_HOLD;
        mark_q  <= '0;
        sar_q   <= '0;
        phase_q <= '0;
      end else begin
        unique case (state_q)
          ST_HOLD: begin
            state_q <= ST_RUN;
            mark_q  <= MSB_ONE;
            phase_q <= '0;
          end
          ST_RUN: begin
            if (phase_q == PH_LAST) begin
              sar_q   <= sar_q | keep;
              mark_q  <= mark_q >> 1;
              phase_q <= '0;
              if (mark_q[0]) begin
                res_q   <= sar_q | keep;
                xfer_q  <= 1'b1;
                state_q <= ST_IDLE;
              end
            end else begin
              phase_q <= phase_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign trial_o  = sar_q | mark_q;
  assign result_o = res_q;
  assign xfer_o   = xfer_q;

  p_hold_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_req_i |=> (trial_o == '0));
  p_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mark_q));
  p_first_trial_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && !start_req_i) |=> (trial_o == MSB_ONE));
  p_xfer_lsb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_q |-> ($past(mark_q[0]) && $past(state_q == ST_RUN)));
endmodule

// File: rtl/sar_intr.sv
`timescale 1ns/1ps
module sar_intr #(
  parameter int PULSE = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic xfer_i,
  input  logic clr_i,
  input  logic start_i,
  output logic flag_o
);
  localparam int CNT_W = $clog2(PULSE + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic             set_act;

  assign set_act = xfer_i || (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (xfer_i)             cnt_q <= CNT_W'(PULSE - 1);
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      // set has priority over any clear
      if (set_act)                flag_q <= 1'b1;
      else if (clr_i || start_i)  flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i |=> flag_q);
  p_clear_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(clr_i || start_i));
  p_flag_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i && !start_i) |=> flag_q);
endmodule

// File: rtl/sar_rdout.sv
`timescale 1ns/1ps
module sar_rdout #(
  parameter int RES_BITS = 10,
  parameter int BUS_W    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sel_i,
  input  logic                rd_i,
  input  logic                start_i,
  input  logic [RES_BITS-1:0] result_i,
  output logic [BUS_W-1:0]    data_o,
  output logic                oe_o
);
  localparam int PAD = 2 * BUS_W - RES_BITS;

  logic [2*BUS_W-1:0] padded;
  logic               ptr_q, rd_q;
  logic [BUS_W-1:0]   sel_byte;

  if (PAD > 0) begin : g_pad
    assign padded = {result_i, {PAD{1'b0}}};
  end else begin : g_nopad
    assign padded = result_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= 1'b0;
      rd_q  <= 1'b0;
    end else begin
      rd_q <= rd_i;
      if (start_i)                   ptr_q <= 1'b0;
      else if (sel_i && rd_q && !rd_i) ptr_q <= ~ptr_q;
    end
  end

  assign sel_byte = ptr_q ? padded[BUS_W-1:0] : padded[2*BUS_W-1:BUS_W];
  assign oe_o     = sel_i && rd_i;
  assign data_o   = oe_o ? sel_byte : '0;

  p_ptr_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !ptr_q);
  p_ptr_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && !start_i) |=> $stable(ptr_q));
endmodule

// File: rtl/sar_conv_ctrl.sv
`timescale 1ns/1ps
module sar_conv_ctrl #(
  parameter int RES_BITS     = 10,
  parameter int BUS_W        = 8,
  parameter int CLKS_PER_BIT = 8,
  parameter int INTR_PULSE   = 20
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_ni,
  input  logic                wr_ni,
  input  logic                rd_ni,
  input  logic                cmp_i,
  output logic [RES_BITS-1:0] dac_code_o,
  output logic                intr_no,
  output logic [BUS_W-1:0]    data_o,
  output logic                data_oe_o
);
  logic [2:0]          strb_s;
  logic                cs_s, wr_s, rd_s;
  logic                start_req, sel, rd_act;
  logic [RES_BITS-1:0] result;
  logic                xfer, flag;

  sar_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({rd_ni, wr_ni, cs_ni}),
    .q_o   (strb_s)
  );
  assign {rd_s, wr_s, cs_s} = strb_s;

  assign sel       = !cs_s;
  assign rd_act    = !rd_s;
  assign start_req = sel && !wr_s;

  sar_seq #(.RES_BITS(RES_BITS), .CLKS_PER_BIT(CLKS_PER_BIT)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_req_i(start_req),
    .cmp_i      (cmp_i),
    .trial_o    (dac_code_o),
    .result_o   (result),
    .xfer_o     (xfer)
  );

  sar_intr #(.PULSE(INTR_PULSE)) u_intr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .xfer_i (xfer),
    .clr_i  (sel && rd_act),
    .start_i(start_req),
    .flag_o (flag)
  );

  sar_rdout #(.RES_BITS(RES_BITS), .BUS_W(BUS_W)) u_rdout (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel),
    .rd_i    (rd_act),
    .start_i (start_req),
    .result_i(result),
    .data_o  (data_o),
    .oe_o    (data_oe_o)
  );

  assign intr_no = !flag;

  p_no_intr_in_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_req && $past(start_req)) |-> !xfer);
endmodule

// File: tb/sar_conv_ctrl_test.sv
`timescale 1ns/1ps
module sar_conv_ctrl_test;
  localparam int PULSE = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, wr_n_d = 1'b1, rd_n = 1'b1;
  logic       free_mode = 1'b0, force_n = 1'b1;
  logic [9:0] ana_v = '0;
  logic       wr_n, cmp;
  logic [9:0] dac_code;
  logic       intr_no, data_oe;
  logic [7:0] data;

  int n_run = 0, n_fail = 0;
  int exp_q[$];
  logic [15:0] got_q[$];

  always #10 clk = ~clk;

  assign wr_n = free_mode ? (intr_no & force_n) : wr_n_d;
  assign cmp  = (ana_v >= dac_code);

  sar_conv_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .wr_ni(wr_n), .rd_ni(rd_n),
    .cmp_i(cmp), .dac_code_o(dac_code), .intr_no(intr_no),
    .data_o(data), .data_oe_o(data_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pop expected codes and compare with byte pairs read back
  always @(negedge clk) begin
    if (got_q.size() != 0) begin
      logic [15:0] g;
      int e;
      g = got_q.pop_front();
      e = (exp_q.size() != 0) ? exp_q.pop_front() : -1;
      chk({g[15:8], g[7:6]} == e[9:0] && e >= 0, "R4 result", {g[15:8], g[7:6]}, e);
      chk(g[5:0] == 6'd0, "R8 low pad", g[5:0], 0);
    end
  end

  task automatic conv(input logic [9:0] v, input int hold, input bit trials, output int lat);
    ana_v = v;
    cs_n = 1'b0; wr_n_d = 1'b0;
    cyc(hold);
    cs_n = 1'b1; wr_n_d = 1'b1;
    lat = 0;
    while (intr_no && lat < 300) begin
      cyc(1);
      lat++;
      if (trials && lat == 6) chk(dac_code == 10'h200, "R3 first trial", dac_code, 10'h200);
      if (trials && lat == 15)
        chk(dac_code == (v[9] ? 10'h300 : 10'h100), "R3 second trial", dac_code,
            v[9] ? 10'h300 : 10'h100);
    end
    chk(lat >= 80 && lat <= 90, "R2 latency", lat, 84);
  endtask

  task automatic rd_byte(output logic [7:0] b);
    cs_n = 1'b0; rd_n = 1'b0;
    cyc(4);
    b = data;
    chk(data_oe == 1'b1, "R6 oe", data_oe, 1);
    chk(intr_no == 1'b1, "R6 read clears", intr_no, 1);
    rd_n = 1'b1;
    cyc(4);
    chk(data_oe == 1'b0 && data == 8'h00, "R8 quiet bus", data, 0);
    cs_n = 1'b1;
    cyc(2);
  endtask

  task automatic read_pair();
    logic [7:0] b0, b1;
    rd_byte(b0);
    rd_byte(b1);
    got_q.push_back({b0, b1});
  endtask

  task automatic conv_read(input logic [9:0] v);
    int lat;
    exp_q.push_back(int'(v));
    conv(v, 3, 1'b1, lat);
    cyc(PULSE + 5);
    chk(intr_no == 1'b0, "R5 intr held", intr_no, 0);
    read_pair();
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    join_none
  end

  initial begin
    int lat, cnt, falls;
    logic [7:0] b;
    logic prev;
    cyc(5);
    chk(intr_no == 1'b1, "R5 reset intr", intr_no, 1);
    chk(data_oe == 1'b0, "R8 reset oe", data_oe, 0);
    chk(data == 8'h00, "R8 reset data", data, 0);
    chk(dac_code == 10'h000, "R1 reset trial", dac_code, 0);
    rst_n = 1'b1;
    cyc(3);

    // R3 R4 several patterns incl. full scale and zero
    conv_read(10'h2AB);
    conv_read(10'h3FF);
    conv_read(10'h000);
    conv_read(10'h155);
    conv_read(10'h001);
    conv_read(10'h200);

    // R9 pointer reset on start and wrap
    conv(10'h0F0, 3, 1'b0, lat);
    cyc(PULSE + 5);
    rd_byte(b);
    chk(b == 8'h3C, "R9 first byte", b, 8'h3C);
    exp_q.push_back(10'h1C3);
    conv(10'h1C3, 3, 1'b0, lat);
    cyc(PULSE + 5);
    read_pair();
    rd_byte(b);
    chk(b == 8'h70, "R9 wrap", b, 8'h70);

    // R1 wide start: clears pending intr, holds search in reset
    conv(10'h0AA, 3, 1'b0, lat);
    cyc(PULSE + 5);
    chk(intr_no == 1'b0, "R5 pending", intr_no, 0);
    ana_v = 10'h333;
    cs_n = 1'b0; wr_n_d = 1'b0;
    cyc(5);
    chk(intr_no == 1'b1, "R1 start clears intr", intr_no, 1);
    cyc(140);
    chk(dac_code == 10'h000, "R1 trial zero in hold", dac_code, 0);
    chk(intr_no == 1'b1, "R1 no intr in hold", intr_no, 1);
    exp_q.push_back(10'h333);
    conv(10'h333, 1, 1'b1, lat);
    cyc(PULSE + 5);
    read_pair();

    // R7 read held enabled: intr still pulses
    ana_v = 10'h2C9;
    cs_n = 1'b0; rd_n = 1'b0;
    cyc(4);
    wr_n_d = 1'b0;
    cyc(3);
    wr_n_d = 1'b1;
    lat = 0;
    while (intr_no && lat < 300) begin cyc(1); lat++; end
    chk(lat >= 80 && lat <= 90, "R2 latency held read", lat, 84);
    cnt = 0;
    while (!intr_no && cnt < 200) begin cnt++; cyc(1); end
    chk(cnt == PULSE, "R7 pulse length", cnt, PULSE);
    chk(data_oe == 1'b1 && data == 8'hB2, "R8 held read byte", data, 8'hB2);
    rd_n = 1'b1;
    cyc(4);
    cs_n = 1'b1;
    cyc(4);

    // R10 free-running loop
    ana_v = 10'h155;
    free_mode = 1'b1; cs_n = 1'b0; force_n = 1'b0;
    cyc(4);
    force_n = 1'b1;
    falls = 0;
    prev = intr_no;
    for (int i = 0; i < 400; i++) begin
      cyc(1);
      if (prev && !intr_no) falls++;
      prev = intr_no;
    end
    chk(falls >= 3 && falls <= 4, "R10 free-run", falls, 3);
    free_mode = 1'b0; cs_n = 1'b1; wr_n_d = 1'b1;
    cyc(10);
    chk(exp_q.size() == 0 && got_q.size() == 0, "R4 scoreboard drained",
        exp_q.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule